// File: doc/BRIEF.md
# AXI Outstanding and Latency Regulator

This block sits on an AXI link between a master and a memory slave and shapes the timing the master sees. It bounds how many reads, how many writes, and how many transactions in total may be in flight. It also holds each read response and each write response until a programmable minimum number of cycles has elapsed since the request that caused it. The result is a memory that looks slower and more constrained than the real one, with timing that can be repeated from run to run. This is useful when measuring how a master performs under a chosen memory profile.

Every accepted read address, and every accepted final write data beat, is pushed as a timestamp into an in-order queue. The response at the head of a queue is passed upstream only once its age has reached the configured latency. Responses therefore leave in the order their requests were accepted. If the slave has not produced a response by the time the head entry becomes due, the block emits a one-cycle underrun pulse for that transaction. When a request is held back because a queue is full, an overflow pulse is emitted. Data payloads are not routed through the block: only the handshake signals are gated, and each response is a single beat.

Top module: `axi_pace_regulator`

## Requirements
- R1: While the read cap `cfg_rd_cap` is non-zero and the number of pending reads equals or exceeds it, `up_ar_ready` and `dn_ar_valid` are low. A read is pending from its AR handshake until its R handshake with last set.
- R2: While the write cap `cfg_wr_cap` is non-zero and the number of pending writes equals or exceeds it, `up_aw_ready` and `dn_aw_valid` are low. A write is pending from its AW handshake until its upstream B handshake.
- R3: While `cfg_all_cap` is non-zero and pending reads plus pending writes equals or exceeds it, both address channels are blocked. When exactly one slot below that cap remains and both address channels request, the read is admitted and the write waits (default variant).
- R4: A cap value of 0 imposes no limit, and lowering a cap to 0 releases a blocked request in the same cycle.
- R5: Pending reads and pending writes are each bounded by DEPTH (default 16) whatever the caps are. A request held back by this bound raises `ev_rd_overflow` or `ev_wr_overflow` in that cycle.
- R6: A read whose AR handshake happens at clock edge E is not shown on `up_r_valid` before the interval that follows edge E+max(`cfg_rd_lat`,1)-1. It is shown in that interval if the slave's R is already valid, and otherwise in the first interval in which the slave's R is valid.
- R7: Write latency is counted from the handshake of the W beat with last set, not from the AW handshake. The rule of R6 applies to `up_b_valid` with `cfg_wr_lat`.
- R8: If a head response becomes due while the slave's response is not valid, `ev_rd_underrun` (reads) or `ev_wr_underrun` (writes) pulses for exactly one cycle for that transaction. Otherwise it stays low.
- R9: `max_pending` reports DEPTH, the largest pending count that the caps can use.
- R10: After reset no response is shown upstream, no event is raised, and an address request is passed through at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_cap | input | CAP_W | Pending read cap, 0 = none |
| cfg_wr_cap | input | CAP_W | Pending write cap, 0 = none |
| cfg_all_cap | input | CAP_W | Pending read+write cap, 0 = none |
| cfg_rd_lat | input | LAT_W | Minimum read latency in cycles |
| cfg_wr_lat | input | LAT_W | Minimum write latency in cycles |
| max_pending | output | CAP_W | Largest usable pending count |
| up_ar_valid | input | 1 | Master read address valid |
| up_ar_ready | output | 1 | Read address ready to master |
| dn_ar_valid | output | 1 | Read address valid to slave |
| dn_ar_ready | input | 1 | Slave read address ready |
| up_aw_valid | input | 1 | Master write address valid |
| up_aw_ready | output | 1 | Write address ready to master |
| dn_aw_valid | output | 1 | Write address valid to slave |
| dn_aw_ready | input | 1 | Slave write address ready |
| up_w_valid | input | 1 | Master write data valid |
| up_w_last | input | 1 | Master final write beat |
| up_w_ready | output | 1 | Write data ready to master |
| dn_w_valid | output | 1 | Write data valid to slave |
| dn_w_ready | input | 1 | Slave write data ready |
| dn_r_valid | input | 1 | Slave read response valid |
| dn_r_last | input | 1 | Slave final read beat |
| dn_r_ready | output | 1 | Read response ready to slave |
| up_r_valid | output | 1 | Read response valid to master |
| up_r_last | output | 1 | Final read beat to master |
| up_r_ready | input | 1 | Master read response ready |
| dn_b_valid | input | 1 | Slave write response valid |
| dn_b_ready | output | 1 | Write response ready to slave |
| up_b_valid | output | 1 | Write response valid to master |
| up_b_ready | input | 1 | Master write response ready |
| ev_rd_underrun | output | 1 | Read deadline missed pulse |
| ev_wr_underrun | output | 1 | Write deadline missed pulse |
| ev_rd_overflow | output | 1 | Read held by queue bound |
| ev_wr_overflow | output | 1 | Write held by queue bound |

## Verification
Latency release is tested with a table of pairs (configured latency, slave response delay). The pairs cover a slave that is early, one that arrives exactly at the deadline, one that is late, and the zero-latency floor. Together they show whether the release cycle is taken as the maximum of the two and whether an underrun fires only when the slave is late. One write case places the W beat several cycles after its address, which separates counting from W last from counting from AW. The cap tests fill each counter up to its limit, then up to the queue depth, and finally use the combined cap with both address channels requesting at once. These expose the blocking, the zero-means-none release, the overflow pulse and the read priority on the final slot.

// File: rtl/axi_pace_pkg.sv
package axi_pace_pkg;
   // Default widths of the configuration fields
   localparam int CAP_W_DEF = 6;
   localparam int LAT_W_DEF = 12;

   // Cap comparison: a zero cap means unlimited
   function automatic logic cap_reached(input int unsigned count, input int unsigned cap);
      return (cap != 0) && (count >= cap);
   endfunction
endpackage

// File: rtl/pace_cap_gate.sv
module pace_cap_gate #(
   parameter int DEPTH = 16,
   parameter int CAP_W = 6,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   input  logic [CAP_W-1:0] cap,
   output logic [CNT_W-1:0] cnt,
   output logic             cap_hit,
   output logic             depth_hit
);
   import axi_pace_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (inc && !dec)
         cnt <= cnt + 1'b1;
      else if (dec && !inc)
         cnt <= cnt - 1'b1;
   end

   assign cap_hit   = cap_reached(int'(cnt), int'(cap));
   assign depth_hit = (int'(cnt) >= DEPTH);
endmodule

// File: rtl/pace_stamp_fifo.sv
module pace_stamp_fifo #(
   parameter int DEPTH = 16,
   parameter int LAT_W = 12,
   localparam int TS_W = LAT_W + 1,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             rsp_valid,
   input  logic [LAT_W-1:0] lat,
   input  logic [TS_W-1:0]  now,
   output logic             full,
   output logic             head_ripe,
   output logic             late_ev
);
   logic [PW-1:0]    wr_ptr, rd_ptr;
   logic [PW:0]      fill;
   logic [DEPTH-1:0] mature;
   logic             late_seen;

   // One timestamp slot per entry; a slot latches "ripe" once its age
   // reaches the latency, so it stays ripe after the counter wraps.
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [TS_W-1:0] stamp;
      logic            ripe;
      logic [TS_W-1:0] age;

      assign age       = now - stamp;
      assign mature[g] = ripe | (age >= TS_W'(lat));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stamp <= '0;
            ripe  <= 1'b0;
         end else if (push && (wr_ptr == PW'(g))) begin
            stamp <= now;
            ripe  <= 1'b0;
         end else begin
            ripe  <= mature[g];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         if (push && !pop)      fill <= fill + 1'b1;
         else if (pop && !push) fill <= fill - 1'b1;
      end
   end

   assign full      = (fill == (PW+1)'(DEPTH));
   assign head_ripe = (fill != '0) && mature[rd_ptr];
   assign late_ev   = head_ripe && !rsp_valid && !late_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        late_seen <= 1'b0;
      else if (pop)      late_seen <= 1'b0;
      else if (late_ev)  late_seen <= 1'b1;
   end
endmodule

// File: rtl/axi_pace_regulator.sv
module axi_pace_regulator #(
   parameter int DEPTH          = 16,
   parameter int CAP_W          = axi_pace_pkg::CAP_W_DEF,
   parameter int LAT_W          = axi_pace_pkg::LAT_W_DEF,
   parameter bit LAST_SLOT_READ = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CAP_W-1:0] cfg_rd_cap,
   input  logic [CAP_W-1:0] cfg_wr_cap,
   input  logic [CAP_W-1:0] cfg_all_cap,
   input  logic [LAT_W-1:0] cfg_rd_lat,
   input  logic [LAT_W-1:0] cfg_wr_lat,
   output logic [CAP_W-1:0] max_pending,
   input  logic             up_ar_valid,
   output logic             up_ar_ready,
   output logic             dn_ar_valid,
   input  logic             dn_ar_ready,
   input  logic             up_aw_valid,
   output logic             up_aw_ready,
   output logic             dn_aw_valid,
   input  logic             dn_aw_ready,
   input  logic             up_w_valid,
   input  logic             up_w_last,
   output logic             up_w_ready,
   output logic             dn_w_valid,
   input  logic             dn_w_ready,
   input  logic             dn_r_valid,
   input  logic             dn_r_last,
   output logic             dn_r_ready,
   output logic             up_r_valid,
   output logic             up_r_last,
   input  logic             up_r_ready,
   input  logic             dn_b_valid,
   output logic             dn_b_ready,
   output logic             up_b_valid,
   input  logic             up_b_ready,
   output logic             ev_rd_underrun,
   output logic             ev_wr_underrun,
   output logic             ev_rd_overflow,
   output logic             ev_wr_overflow
);
   import axi_pace_pkg::*;

   localparam int TS_W  = LAT_W + 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || DEPTH > (1 << CAP_W) - 1 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two between 2 and the cap range");
   end
   if (LAT_W < 1) begin : g_bad_lat
      $error("LAT_W must be at least 1");
   end

   logic [TS_W-1:0]  now_q;
   logic [CNT_W-1:0] rd_pend, wr_pend;
   logic             rd_cap_hit, rd_depth_hit, wr_cap_hit, wr_depth_hit;
   logic             rq_full, rq_ripe, wq_full, wq_ripe;
   logic             ar_hs, aw_hs, wlast_hs, r_done, b_done;
   logic             all_hit, all_last, ar_base, aw_base, ar_ok, aw_ok;
   logic [CNT_W:0]   total;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now_q <= '0;
      else        now_q <= now_q + 1'b1;
   end

   assign ar_hs    = dn_ar_valid & dn_ar_ready;
   assign aw_hs    = dn_aw_valid & dn_aw_ready;
   assign wlast_hs = dn_w_valid & dn_w_ready & up_w_last;
   assign r_done   = up_r_valid & up_r_ready & up_r_last;
   assign b_done   = up_b_valid & up_b_ready;

   pace_cap_gate #(.DEPTH(DEPTH), .CAP_W(CAP_W)) u_rd_gate (
      .clk(clk), .rst_n(rst_n), .inc(ar_hs), .dec(r_done), .cap(cfg_rd_cap),
      .cnt(rd_pend), .cap_hit(rd_cap_hit), .depth_hit(rd_depth_hit));

   pace_cap_gate #(.DEPTH(DEPTH), .CAP_W(CAP_W)) u_wr_gate (
      .clk(clk), .rst_n(rst_n), .inc(aw_hs), .dec(b_done), .cap(cfg_wr_cap),
      .cnt(wr_pend), .cap_hit(wr_cap_hit), .depth_hit(wr_depth_hit));

   assign total    = {1'b0, rd_pend} + {1'b0, wr_pend};
   assign all_hit  = cap_reached(int'(total), int'(cfg_all_cap));
   assign all_last = (cfg_all_cap != '0) && (int'(total) + 1 == int'(cfg_all_cap));

   assign ar_base = !rd_cap_hit && !rd_depth_hit && !all_hit;
   assign aw_base = !wr_cap_hit && !wr_depth_hit && !all_hit;

   // Arbitration of the final combined slot when both channels ask for it
   if (LAST_SLOT_READ) begin : g_read_first
      assign ar_ok = ar_base;
      assign aw_ok = aw_base && !(all_last && up_ar_valid && ar_base);
   end else begin : g_write_first
      assign aw_ok = aw_base;
      assign ar_ok = ar_base && !(all_last && up_aw_valid && aw_base);
   end

   assign dn_ar_valid = up_ar_valid & ar_ok;
   assign up_ar_ready = dn_ar_ready & ar_ok;
   assign dn_aw_valid = up_aw_valid & aw_ok;
   assign up_aw_ready = dn_aw_ready & aw_ok;
   assign dn_w_valid  = up_w_valid & !wq_full;
   assign up_w_ready  = dn_w_ready & !wq_full;

   pace_stamp_fifo #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_rd_q (
      .clk(clk), .rst_n(rst_n), .push(ar_hs), .pop(r_done), .rsp_valid(dn_r_valid),
      .lat(cfg_rd_lat), .now(now_q), .full(rq_full), .head_ripe(rq_ripe),
      .late_ev(ev_rd_underrun));

   pace_stamp_fifo #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_wr_q (
      .clk(clk), .rst_n(rst_n), .push(wlast_hs), .pop(b_done), .rsp_valid(dn_b_valid),
      .lat(cfg_wr_lat), .now(now_q), .full(wq_full), .head_ripe(wq_ripe),
      .late_ev(ev_wr_underrun));

   assign up_r_valid = dn_r_valid & rq_ripe;
   assign dn_r_ready = up_r_ready & rq_ripe;
   assign up_r_last  = dn_r_last;
   assign up_b_valid = dn_b_valid & wq_ripe;
   assign dn_b_ready = up_b_ready & wq_ripe;

   assign ev_rd_overflow = up_ar_valid & rq_full;
   assign ev_wr_overflow = (up_aw_valid & wr_depth_hit) | (up_w_valid & wq_full);
   assign max_pending    = CAP_W'(DEPTH);
endmodule

// File: rtl/axi_pace_checker.sv
module axi_pace_checker #(
   parameter int DEPTH = 16,
   parameter int CAP_W = 6,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CAP_W-1:0] cfg_rd_cap,
   input logic [CAP_W-1:0] cfg_wr_cap,
   input logic [CAP_W-1:0] cfg_all_cap,
   input logic [CNT_W-1:0] rd_pend,
   input logic [CNT_W-1:0] wr_pend,
   input logic             dn_ar_valid,
   input logic             dn_aw_valid,
   input logic             up_r_valid,
   input logic             dn_r_valid,
   input logic             up_b_valid,
   input logic             dn_b_valid,
   input logic             ev_rd_underrun
);
   AST_RD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_cap != 0 && int'(rd_pend) >= int'(cfg_rd_cap)) |-> !dn_ar_valid); // R1
   AST_WR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_cap != 0 && int'(wr_pend) >= int'(cfg_wr_cap)) |-> !dn_aw_valid); // R2
   AST_ALL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_all_cap != 0 && int'(rd_pend) + int'(wr_pend) >= int'(cfg_all_cap))
      |-> (!dn_ar_valid && !dn_aw_valid)); // R3
   AST_RD_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rd_pend) <= DEPTH && int'(wr_pend) <= DEPTH); // R5
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      up_r_valid |-> dn_r_valid); // R6
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      up_b_valid |-> dn_b_valid); // R7
   AST_UR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rd_underrun |=> !ev_rd_underrun); // R8
endmodule

bind axi_pace_regulator axi_pace_checker #(.DEPTH(DEPTH), .CAP_W(CAP_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_rd_cap(cfg_rd_cap), .cfg_wr_cap(cfg_wr_cap),
   .cfg_all_cap(cfg_all_cap), .rd_pend(rd_pend), .wr_pend(wr_pend),
   .dn_ar_valid(dn_ar_valid), .dn_aw_valid(dn_aw_valid), .up_r_valid(up_r_valid),
   .dn_r_valid(dn_r_valid), .up_b_valid(up_b_valid), .dn_b_valid(dn_b_valid),
   .ev_rd_underrun(ev_rd_underrun));

// File: tb/test_axi_pace_regulator.sv
`timescale 1ns/1ps
module test_axi_pace_regulator;
   localparam int DEPTH = 16;
   localparam int CAP_W = 6;
   localparam int LAT_W = 12;
   localparam real HALF = 10.0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CAP_W-1:0] cfg_rd_cap = '0, cfg_wr_cap = '0, cfg_all_cap = '0;
   logic [LAT_W-1:0] cfg_rd_lat = '0, cfg_wr_lat = '0;
   logic [CAP_W-1:0] max_pending;
   logic up_ar_valid = 0, up_ar_ready, dn_ar_valid, dn_ar_ready = 1;
   logic up_aw_valid = 0, up_aw_ready, dn_aw_valid, dn_aw_ready = 1;
   logic up_w_valid = 0, up_w_last = 0, up_w_ready, dn_w_valid, dn_w_ready = 1;
   logic dn_r_valid = 0, dn_r_last = 1, dn_r_ready, up_r_valid, up_r_last, up_r_ready = 1;
   logic dn_b_valid = 0, dn_b_ready, up_b_valid, up_b_ready = 1;
   logic ev_rd_underrun, ev_wr_underrun, ev_rd_overflow, ev_wr_overflow;

   int n_chk = 0;
   int n_fail = 0;

   always #(HALF) clk = ~clk;

   axi_pace_regulator #(.DEPTH(DEPTH), .CAP_W(CAP_W), .LAT_W(LAT_W)) i_axi_pace_regulator (.*);

   // Columns: read latency, slave delay (interval), expected release interval, expected underruns
   localparam int ROWS = 8;
   localparam int VEC [ROWS][4] = '{
      '{0, 1, 1, 0}, '{3, 1, 3, 0}, '{5, 5, 5, 0}, '{2, 6, 6, 1},
      '{10, 4, 10, 0}, '{1, 3, 3, 1}, '{0, 4, 4, 1}, '{12, 13, 13, 1}};

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic rd_issue();
      @(negedge clk); up_ar_valid = 1'b1;
      @(negedge clk); up_ar_valid = 1'b0;
   endtask

   task automatic rd_drain(input int n);
      int got;
      got = 0;
      dn_r_valid = 1'b1;
      for (int t = 0; t < 400 && got < n; t++) begin
         #1;
         if (up_r_valid) got++;
         @(negedge clk);
      end
      dn_r_valid = 1'b0;
   endtask

   task automatic wr_finish();
      @(negedge clk); up_w_valid = 1'b1; up_w_last = 1'b1;
      @(negedge clk); up_w_valid = 1'b0; up_w_last = 1'b0;
      dn_b_valid = 1'b1;
      for (int t = 0; t < 400; t++) begin
         #1;
         if (up_b_valid) break;
         @(negedge clk);
      end
      @(negedge clk); dn_b_valid = 1'b0;
   endtask

   task automatic wr_run(input int gap, input int lat, input int d, output int first, output int urs);
      cfg_wr_lat = LAT_W'(lat);
      @(negedge clk); up_aw_valid = 1'b1;
      @(negedge clk); up_aw_valid = 1'b0;
      repeat (gap) @(negedge clk);
      up_w_valid = 1'b1; up_w_last = 1'b1;
      @(negedge clk); up_w_valid = 1'b0; up_w_last = 1'b0;
      first = 0; urs = 0;
      for (int k = 1; k <= 60 && first == 0; k++) begin
         if (k > 1) @(negedge clk);
         dn_b_valid = (k >= d);
         #1;
         urs += int'(ev_wr_underrun);
         if (up_b_valid) first = k;
      end
      @(negedge clk); dn_b_valid = 1'b0;
   endtask

   initial begin
      #(HALF * 2 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int lat, d, first, urs;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check("R10 ar ready after reset", int'(up_ar_ready), 1);
      check("R10 r valid after reset", int'(up_r_valid), 0);
      check("R10 b valid after reset", int'(up_b_valid), 0);
      check("R10 events after reset", int'({ev_rd_underrun, ev_wr_underrun, ev_rd_overflow, ev_wr_overflow}), 0);
      check("R9 max pending", int'(max_pending), DEPTH);

      // Table: read latency vs slave delay (R6, R8)
      for (int i = 0; i < ROWS; i++) begin
         lat = VEC[i][0]; d = VEC[i][1]; first = 0; urs = 0;
         cfg_rd_lat = LAT_W'(lat);
         rd_issue();
         for (int k = 1; k <= 60 && first == 0; k++) begin
            if (k > 1) @(negedge clk);
            dn_r_valid = (k >= d);
            #1;
            urs += int'(ev_rd_underrun);
            if (up_r_valid) first = k;
         end
         @(negedge clk); dn_r_valid = 1'b0;
         check($sformatf("R6 release row %0d", i), first, VEC[i][2]);
         check($sformatf("R8 underrun row %0d", i), urs, VEC[i][3]);
      end

      // Write latency counted from W last, address sent well before (R7)
      wr_run(6, 4, 1, first, urs);
      check("R7 write release from W last", first, 4);
      check("R8 write no underrun", urs, 0);
      wr_run(0, 2, 7, first, urs);
      check("R7 late slave write release", first, 7);
      check("R8 write underrun once", urs, 1);

      // Read cap, then zero releases (R1, R4)
      cfg_rd_lat = '0;
      cfg_rd_cap = 6'd2;
      rd_issue(); rd_issue();
      @(negedge clk); up_ar_valid = 1'b1; #1;
      check("R1 ar ready at cap", int'(up_ar_ready), 0);
      check("R1 dn ar valid at cap", int'(dn_ar_valid), 0);
      cfg_rd_cap = '0; #1;
      check("R4 zero cap releases", int'(up_ar_ready), 1);
      @(negedge clk); up_ar_valid = 1'b0;
      rd_drain(3);

      // Depth bound with no cap (R5)
      for (int j = 0; j < DEPTH; j++) rd_issue();
      @(negedge clk); up_ar_valid = 1'b1; #1;
      check("R5 ar blocked at depth", int'(up_ar_ready), 0);
      check("R5 overflow event", int'(ev_rd_overflow), 1);
      up_ar_valid = 1'b0;
      rd_drain(DEPTH);
      #1;
      check("R5 overflow clears", int'(ev_rd_overflow), 0);

      // Write cap (R2)
      cfg_wr_lat = '0;
      cfg_wr_cap = 6'd1;
      @(negedge clk); up_aw_valid = 1'b1;
      @(negedge clk); #1;
      check("R2 aw ready at cap", int'(up_aw_ready), 0);
      check("R2 dn aw valid at cap", int'(dn_aw_valid), 0);
      up_aw_valid = 1'b0;
      wr_finish();
      @(negedge clk); up_aw_valid = 1'b1; #1;
      check("R2 aw accepted after B", int'(up_aw_ready), 1);
      @(negedge clk); up_aw_valid = 1'b0;
      wr_finish();
      cfg_wr_cap = '0;

      // Combined cap with the final slot contested (R3)
      cfg_all_cap = 6'd3;
      rd_issue(); rd_issue();
      @(negedge clk); up_ar_valid = 1'b1; up_aw_valid = 1'b1; #1;
      check("R3 read wins last slot", int'(dn_ar_valid), 1);
      check("R3 write waits on last slot", int'(dn_aw_valid), 0);
      @(negedge clk); #1;
      check("R3 ar blocked at total cap", int'(up_ar_ready), 0);
      check("R3 aw blocked at total cap", int'(up_aw_ready), 0);
      up_ar_valid = 1'b0; up_aw_valid = 1'b0;
      rd_drain(3);
      cfg_all_cap = '0;

      finish_run();
   end
endmodule